// File: doc/BRIEF.md
# I2C Command and Result Readout Slave

This block is the serial front end of an isolated monitoring converter. It sits on a two-wire I2C/SMBus bus as a slave with a fixed seven-bit address of 1111000. A master sends it one configuration command per write transfer. On a read transfer the master gets back three bytes. The first is the echo of the configuration. The second and third are the high and low bytes of the conversion result.

The bus lines are sampled by the block's own clock. They pass through a synchronizer and a glitch filter before any START, STOP or clock edge is recognised. The block never drives SDA high. It pulls SDA low by raising an open-drain enable, and it does this only while SCL is low. A command byte that has been received is handed to the user side as a one-cycle strobe together with the byte. The three read bytes come from a parallel source word that the user side keeps up to date.

Top module: `i2c_cmd_port`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe` is 0 and `cmd_valid` is 0.
- R2: An address byte of 0xF0 (1111000 then R/W=0) or 0xF1 (R/W=1) is acknowledged. The slave raises `sda_oe` for the whole ninth SCL clock.
- R3: Any other address byte is not acknowledged. All following bits, including full bytes, leave `sda_oe` at 0 and produce no `cmd_valid` until the next START.
- R4: In a write transfer the first byte after the address is acknowledged. It is presented on `cmd_data` (first bit received = bit 7) with a `cmd_valid` pulse exactly one clock long.
- R5: Bytes that follow the command byte in the same write transfer are neither acknowledged nor delivered.
- R6: In a read transfer the slave sends `rd_data[23:16]`, then `[15:8]`, then `[7:0]`, MSB first. For a 0 bit `sda_oe` is 1 during the SCL high time, and for a 1 bit it is 0. `rd_data` is captured when the address acknowledge clock ends. `sda_oe` changes only while the filtered SCL is low.
- R7: If the master does not acknowledge a read byte (SDA high in the ninth clock), the slave releases SDA. It keeps SDA released for every later clock until a START or STOP. After the third byte it also releases SDA.
- R8: A repeated START (SDA falls while SCL is high, with no STOP before it) restarts address reception from any state.
- R9: A STOP (SDA rises while SCL is high) returns the slave to idle with SDA released, even in the middle of a read byte.
- R10: A pulse on SCL or SDA shorter than `FILT_LEN` clocks after synchronization is not seen as a clock edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; it oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| rd_data | input | 8*RD_BYTES | Read source: echo byte, result high byte, result low byte (MSB first) |
| cmd_valid | output | 1 | One-clock strobe when a command byte arrives |
| cmd_data | output | 8 | Last command byte received |

## Verification
A wrong bit counter or a wrong state shows up as an acknowledge on the wrong clock, or as a missing one. The bench sees it on the very next SCL high phase. A lost ignore condition shows up as SDA pulled low during bytes that should pass untouched, and the bench clocks such bytes on purpose after a mismatched address, a master NACK and a STOP. A wrong shift order in the read path changes the level of `sda_oe` in the first differing bit time. A wrong delivery path shows up as an extra, missing or lengthened `cmd_valid` pulse, which the bench checks at the end of each transfer.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } port_state_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   out_d;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  // output follows only after FILT_LEN consecutive differing samples
  always_comb begin
    out_d = line_o;
    cnt_d = '0;
    if (synced != line_o) begin
      if (cnt_q == CW'(FILT_LEN - 1)) out_d = synced;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      line_o <= out_d;
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign start_evt = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_evt  = scl_f & scl_p & ~sda_p & sda_f;
  assign scl_rise  = ~scl_p & scl_f;
  assign scl_fall  = scl_p & ~scl_f;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h78,
  parameter int         RD_BYTES = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_evt,
  input  logic                       stop_evt,
  input  logic                       scl_rise,
  input  logic                       scl_fall,
  input  logic                       sda_f,
  input  logic [RD_BYTES*BYTE_W-1:0] rd_data,
  output logic                       sda_oe,
  output logic                       cmd_valid,
  output logic [BYTE_W-1:0]          cmd_data,
  output port_state_e                state
);
  localparam int TXW = RD_BYTES * BYTE_W;
  localparam int IW  = (RD_BYTES > 1) ? $clog2(RD_BYTES) : 1;

  port_state_e       st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [TXW-1:0]    tx_q, tx_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              rw_q, rw_d;
  logic              seen_q, seen_d;
  logic              mack_q, mack_d;
  logic              got_q, got_d;
  logic              oe_q, oe_d;
  logic              cv_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    idx_d  = idx_q;
    rw_d   = rw_q;
    seen_d = seen_q;
    mack_d = mack_q;
    got_d  = got_q;
    oe_d   = oe_q;
    cv_d   = 1'b0;
    cmd_d  = cmd_q;
    if (start_evt) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
      got_d = 1'b0;
    end else if (stop_evt) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (sh_q[7:1] == DEV_ADDR) begin
              oe_d   = 1'b1;
              rw_d   = sh_q[0];
              seen_d = 1'b0;
              st_d   = ST_AACK;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_rise) seen_d = 1'b1;
          else if (scl_fall && seen_q) begin
            cnt_d = '0;
            if (rw_q) begin
              tx_d  = rd_data;
              idx_d = '0;
              oe_d  = ~rd_data[TXW-1];
              st_d  = ST_RDATA;
            end else begin
              oe_d = 1'b0;
              st_d = ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (!got_q) begin
              oe_d   = 1'b1;
              cv_d   = 1'b1;
              cmd_d  = sh_q;
              got_d  = 1'b1;
              seen_d = 1'b0;
              st_d   = ST_WACK;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_WACK: begin
          if (scl_rise) seen_d = 1'b1;
          else if (scl_fall && seen_q) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) cnt_d = cnt_q + 4'd1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d   = 1'b0;
              seen_d = 1'b0;
              st_d   = ST_RACK;
            end else if (cnt_q != 4'd0) begin
              tx_d = tx_q << 1;
              oe_d = ~tx_q[TXW-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            seen_d = 1'b1;
            mack_d = ~sda_f;
          end else if (scl_fall && seen_q) begin
            if (mack_q && idx_q != IW'(RD_BYTES - 1)) begin
              idx_d = idx_q + 1'b1;
              tx_d  = tx_q << 1;
              oe_d  = ~tx_q[TXW-2];
              cnt_d = '0;
              st_d  = ST_RDATA;
            end else begin
              oe_d = 1'b0;
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      idx_q     <= '0;
      rw_q      <= 1'b0;
      seen_q    <= 1'b0;
      mack_q    <= 1'b0;
      got_q     <= 1'b0;
      oe_q      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_q     <= '0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      tx_q      <= tx_d;
      idx_q     <= idx_d;
      rw_q      <= rw_d;
      seen_q    <= seen_d;
      mack_q    <= mack_d;
      got_q     <= got_d;
      oe_q      <= oe_d;
      cmd_valid <= cv_d;
      cmd_q     <= cmd_d;
    end
  end

  assign sda_oe   = oe_q;
  assign cmd_data = cmd_q;
  assign state    = st_q;
endmodule

// File: rtl/i2c_cmd_port.sv
module i2c_cmd_port
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h78,
  parameter int         RD_BYTES    = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  input  logic [RD_BYTES*BYTE_W-1:0] rd_data,
  output logic                       cmd_valid,
  output logic [BYTE_W-1:0]          cmd_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, flt_lines;
  logic              scl_flt, sda_flt;
  logic              start_evt, stop_evt, scl_rise, scl_fall;
  port_state_e       fsm_state;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw_lines[g]),
      .line_o(flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[0];
  assign sda_flt = flt_lines[1];

  i2c_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_flt),
    .sda_f    (sda_flt),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_slave_fsm #(
    .DEV_ADDR(DEV_ADDR),
    .RD_BYTES(RD_BYTES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_f    (sda_flt),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .cmd_valid(cmd_valid),
    .cmd_data (cmd_data),
    .state    (fsm_state)
  );
endmodule

// File: rtl/i2c_cmd_port_chk.sv
module i2c_cmd_port_chk
  import i2c_cmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        cmd_valid,
  input logic        scl_flt,
  input logic        stop_evt,
  input port_state_e st
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!sda_oe && !cmd_valid);
    end
  end

  // R4
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R4
  cmd_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> sda_oe);

  // R6
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_flt);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R3
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_oe);
endmodule

bind i2c_cmd_port i2c_cmd_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .cmd_valid(cmd_valid),
  .scl_flt  (scl_flt),
  .stop_evt (stop_evt),
  .st       (fsm_state)
);

// File: tb/sim_i2c_cmd_port.sv
module sim_i2c_cmd_port;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;

  logic        clk;
  logic        rst_n;
  logic        m_scl;
  logic        m_sda;
  logic        sda_oe;
  logic        sda_line;
  logic [23:0] rd_data;
  logic        cmd_valid;
  logic [7:0]  cmd_data;

  int vectors;
  int fails;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  assign sda_line = m_sda & ~sda_oe;

  i2c_cmd_port u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .rd_data  (rd_data),
    .cmd_valid(cmd_valid),
    .cmd_data (cmd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // every clock: collect delivered commands (one entry per strobe cycle)
  always @(negedge clk) begin
    if (rst_n && cmd_valid) got_q.push_back(cmd_data);
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  // one bit: master level, expected slave enable in the high phase
  task automatic clk_bit(input string req, input logic mbit, input logic exp_oe,
                         input logic glitch);
    m_sda = mbit;
    if (glitch) begin
      wq(Q / 2);
      m_scl = 1'b1; wq(1); m_scl = 1'b0;
      wq(Q / 2 - 1);
    end else begin
      wq(Q);
    end
    m_scl = 1'b1;
    wq(Q / 2);
    if (glitch && mbit) begin
      m_sda = 1'b0; wq(1); m_sda = 1'b1;
    end
    chk(req, {7'd0, sda_oe}, {7'd0, exp_oe});
    wq(Q / 2);
    m_scl = 1'b0;
    wq(Q);
  endtask

  task automatic send_byte(input string req, input logic [7:0] b, input logic exp_ack,
                           input logic glitch);
    for (int i = 7; i >= 0; i--) clk_bit(req, b[i], 1'b0, glitch);
    clk_bit(req, 1'b1, exp_ack, 1'b0);
  endtask

  task automatic recv_byte(input string req, input logic [7:0] exp_b, input logic mack);
    for (int i = 7; i >= 0; i--) clk_bit(req, 1'b1, ~exp_b[i], 1'b0);
    clk_bit(req, ~mack, 1'b0, 1'b0);
  endtask

  task automatic cmp_cmds(input string req);
    chk(req, 8'(got_q.size()), 8'(exp_q.size()));
    while (got_q.size() > 0 && exp_q.size() > 0)
      chk(req, got_q.pop_front(), exp_q.pop_front());
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    vectors = 0;
    fails   = 0;
    m_scl   = 1'b1;
    m_sda   = 1'b1;
    rd_data = 24'hFE_96_3C;
    rst_n   = 1'b0;
    wq(5);
    // R1 reset state
    chk("R1 oe", {7'd0, sda_oe}, 8'd0);
    chk("R1 valid", {7'd0, cmd_valid}, 8'd0);
    rst_n = 1'b1;
    wq(10);
    chk("R1 oe after release", {7'd0, sda_oe}, 8'd0);

    // R2 R4: plain write of a command
    bus_start();
    send_byte("R2 write address ack", 8'hF0, 1'b1, 1'b0);
    send_byte("R4 command ack", 8'hA5, 1'b1, 1'b0);
    exp_q.push_back(8'hA5);
    bus_stop();
    cmp_cmds("R4 command delivered");

    // R5: extra bytes ignored
    bus_start();
    send_byte("R2 write address ack", 8'hF0, 1'b1, 1'b0);
    send_byte("R4 command ack", 8'h3C, 1'b1, 1'b0);
    exp_q.push_back(8'h3C);
    send_byte("R5 extra byte not acked", 8'h99, 1'b0, 1'b0);
    send_byte("R5 extra byte not acked", 8'h00, 1'b0, 1'b0);
    bus_stop();
    cmp_cmds("R5 only first byte delivered");

    // R3 mismatch, then R8 repeated start into a valid write
    bus_start();
    send_byte("R3 foreign address not acked", 8'hA0, 1'b0, 1'b0);
    send_byte("R3 ignored byte", 8'h00, 1'b0, 1'b0);
    send_byte("R3 ignored byte", 8'hF0, 1'b0, 1'b0);
    bus_start();
    send_byte("R8 address after repeated start", 8'hF0, 1'b1, 1'b0);
    send_byte("R8 command after repeated start", 8'h5A, 1'b1, 1'b0);
    exp_q.push_back(8'h5A);
    bus_stop();
    cmp_cmds("R3 R8 delivered set");

    // R6: full read of three bytes after a write, joined by repeated start
    rd_data = 24'hFE_96_3C;
    bus_start();
    send_byte("R2 write address ack", 8'hF0, 1'b1, 1'b0);
    send_byte("R4 command ack", 8'hFE, 1'b1, 1'b0);
    exp_q.push_back(8'hFE);
    bus_start();
    send_byte("R2 read address ack", 8'hF1, 1'b1, 1'b0);
    recv_byte("R6 echo byte", 8'hFE, 1'b1);
    recv_byte("R6 high byte", 8'h96, 1'b1);
    recv_byte("R6 low byte", 8'h3C, 1'b1);
    // R7 released after the last byte
    clk_bit("R7 release after last byte", 1'b1, 1'b0, 1'b0);
    bus_stop();
    cmp_cmds("R6 command in combined transfer");

    // R6 other pattern, R7 master NACK after first byte
    rd_data = 24'hA5_00_00;
    bus_start();
    send_byte("R2 read address ack", 8'hF1, 1'b1, 1'b0);
    recv_byte("R6 echo byte pattern 2", 8'hA5, 1'b0);
    for (int k = 0; k < 9; k++) clk_bit("R7 released after NACK", 1'b1, 1'b0, 1'b0);
    bus_stop();

    // R9 STOP in the middle of a read byte
    rd_data = 24'hE0_00_00;
    bus_start();
    send_byte("R2 read address ack", 8'hF1, 1'b1, 1'b0);
    clk_bit("R6 bit 7", 1'b1, 1'b0, 1'b0);
    clk_bit("R6 bit 6", 1'b1, 1'b0, 1'b0);
    bus_stop();
    for (int k = 0; k < 9; k++) clk_bit("R9 released after STOP", 1'b1, 1'b0, 1'b0);
    chk("R9 idle oe", {7'd0, sda_oe}, 8'd0);

    // R10 glitches on both lines during a write
    bus_start();
    send_byte("R10 address with glitches", 8'hF0, 1'b1, 1'b1);
    send_byte("R10 command with glitches", 8'hC3, 1'b1, 1'b1);
    exp_q.push_back(8'hC3);
    bus_stop();
    cmp_cmds("R10 command unaffected");

    wq(20);
    summary();
    $finish;
  end
endmodule